// File: doc/BRIEF.md
# Serial Bus Command Responder

This block sits behind the byte transfer logic of a serial desktop-peripheral bus host. Once an outgoing transfer has finished, the transfer logic hands over the collected command bytes and their count in a single cycle. The responder works out what kind of command it is and builds the reply bytes that the transfer logic will return on the next inbound transfer. It then raises `done` for one cycle. Malformed or unsupported commands raise `err` together with `done`. The block never stalls on them.

Commands fall into two classes. A bus command can be a bus reset, a talk, or a listen. Talk reads a device register, and listen is used here only to move the keyboard to a new address. A housekeeping command can be an autopoll acknowledge or a read of a 32-bit seconds count. The block keeps the current keyboard address as internal state. It also holds the seconds counter, which advances on a one-second tick and can be preset.

The control path is a three-state machine:
- `ST_IDLE` moves to `ST_DECODE` when a command is accepted.
- `ST_DECODE` always moves to `ST_DONE`. In this state the reply, the error flag and any keyboard relocation are registered.
- `ST_DONE` always moves back to `ST_IDLE`. This state drives `done`.

Top module: `sbr_responder`

## Requirements
- R1: After reset, `done`, `err`, `rsp_len` and `rsp_data` are all zero, and the keyboard address is 2.
- R2: An error is raised for any command shorter than 2 bytes, and for any command whose byte 0 (the class) is neither 0 nor 1. An error gives `err`=1 in the `done` cycle, `rsp_len`=0 and all-zero `rsp_data`.
- R3: A class-0 command whose byte 1 is 0x00 is a bus reset. It gives `rsp_len`=0 and no error.
- R4: A class-0 command is a talk when bits 3:2 of byte 1 are 2'b11 and bits 7:4 of byte 1 are not the keyboard address. The reply is 3 bytes: 0x00, 0x00, then byte 1. Reply byte i is `rsp_data[8i+7:8i]`, and bytes at or beyond `rsp_len` are zero.
- R5: A talk whose bits 7:4 of byte 1 equal the keyboard address replies with 5 bytes: 0x01, 0x01, byte 1, 0x01, 0x01.
- R6: A class-0 command is a listen when bits 3:2 of byte 1 are 2'b10. A listen is accepted only when all of these hold: at least 4 bytes, bits 7:4 of byte 1 equal the keyboard address, bits 7:4 of byte 2 are 0x6, and byte 3 is 0xFE. An accepted listen sets the keyboard address to bits 3:0 of byte 2 and gives `rsp_len`=0. Any other listen is an error and leaves the address unchanged.
- R7: A class-1 command of exactly 3 bytes with bytes 1 and 2 both 0x01 is an autopoll acknowledge. It replies 0x00, 0x00, 0x01.
- R8: A class-1 command of exactly 2 bytes with byte 1 equal to 0x03 replies with the 4 bytes of the seconds counter, most significant first. The counter increments at each clock edge where `sec_tick`=1. It takes `sec_preset` at each edge where `sec_load`=1, and load wins over tick.
- R9: Every other class-1 encoding is an error. This includes byte 1 = 0x11, and the autopoll or clock-read bytes with the wrong length.
- R10: A command is accepted when `cmd_valid` is sampled high in the idle state. `done` is high for exactly one cycle, two clock edges after acceptance. `cmd_valid` is ignored while a command is in flight.
- R11: `rsp_len` and `rsp_data` change only at the edge that raises `done`, and hold their values until the next command completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command buffer and count are valid this cycle |
| cmd_len | input | LEN_W (3) | Number of command bytes |
| cmd_data | input | CMD_MAX*8 (32) | Command bytes, byte i at bits 8i+7:8i |
| sec_tick | input | 1 | One-second advance of the seconds counter |
| sec_load | input | 1 | Load the seconds counter from `sec_preset` |
| sec_preset | input | 32 | Preset value for the seconds counter |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported or malformed command, valid with `done` |
| rsp_len | output | 3 | Number of reply bytes |
| rsp_data | output | 40 | Reply bytes, byte i at bits 8i+7:8i |

## Verification
The bench steers commands into the edges of the decode:
- Listen is tried with each of its four qualifiers broken in turn. A decoder that skipped one of them would move the keyboard, and later talks would reply with the wrong length.
- Talk is sent both to the relocated keyboard address and to the old address 2. A design that kept a stale address would swap the 3-byte and 5-byte replies.
- Autopoll and clock-read bytes are sent with one byte too many or too few. A design that ignored the count would answer instead of flagging an error.
- A preset and a tick are applied in the same cycle. A design with the wrong priority would return a seconds value off by one.
- `cmd_valid` is held high through a command in flight. A design that re-accepted it would produce an extra `done`.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int          RSP_MAX        = 5;
    localparam int          RSP_LEN_W      = $clog2(RSP_MAX + 1);
    localparam int          SEC_W          = 32;
    localparam int          SEC_BYTES      = SEC_W / 8;
    localparam logic [3:0]  KBD_RESET_ADDR = 4'd2;
    localparam logic [3:0]  LISTEN_HI      = 4'h6;
    localparam logic [7:0]  LISTEN_TAIL    = 8'hFE;
    localparam logic [7:0]  CLOCK_READ     = 8'h03;
    localparam logic [7:0]  POLL_ARG       = 8'h01;
    localparam logic [7:0]  KBD_FILL       = 8'h01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DONE
    } sbr_state_e;

    typedef enum logic [2:0] {
        K_BAD,
        K_BUSRST,
        K_TALK,
        K_LISTEN,
        K_AUTOPOLL,
        K_CLOCK
    } cmd_kind_e;

endpackage

// File: rtl/sbr_classifier.sv
module sbr_classifier
    import sbr_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [31:0]      cmd_bytes,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [3:0]       kbd_addr,
    output cmd_kind_e        kind,
    output logic             kbd_hit
);
    logic [7:0] b0, b1, b2, b3;

    assign b0      = cmd_bytes[7:0];
    assign b1      = cmd_bytes[15:8];
    assign b2      = cmd_bytes[23:16];
    assign b3      = cmd_bytes[31:24];
    assign kbd_hit = (b1[7:4] == kbd_addr);

    always_comb begin
        kind = K_BAD;
        if (cmd_len >= LEN_W'(2)) begin
            if (b0 == 8'd0) begin
                if (b1 == 8'd0) begin
                    kind = K_BUSRST;
                end else if (b1[3:2] == 2'b11) begin
                    kind = K_TALK;
                end else if (b1[3:2] == 2'b10 && cmd_len >= LEN_W'(4) &&
                             kbd_hit && b2[7:4] == LISTEN_HI &&
                             b3 == LISTEN_TAIL) begin
                    kind = K_LISTEN;
                end
            end else if (b0 == 8'd1) begin
                if (cmd_len == LEN_W'(3) && b1 == POLL_ARG && b2 == POLL_ARG) begin
                    kind = K_AUTOPOLL;
                end else if (cmd_len == LEN_W'(2) && b1 == CLOCK_READ) begin
                    kind = K_CLOCK;
                end
            end
        end
    end

endmodule

// File: rtl/sbr_rsp_builder.sv
module sbr_rsp_builder
    import sbr_pkg::*;
(
    input  cmd_kind_e              kind,
    input  logic                   kbd_hit,
    input  logic [7:0]             echo,
    input  logic [SEC_W-1:0]       secs,
    output logic [RSP_MAX*8-1:0]   rsp,
    output logic [RSP_LEN_W-1:0]   rsp_len,
    output logic                   rsp_err
);
    logic [7:0] rb [RSP_MAX];

    always_comb begin
        for (int i = 0; i < RSP_MAX; i++) rb[i] = 8'd0;
        rsp_len = '0;
        rsp_err = 1'b0;
        unique case (kind)
            K_BUSRST, K_LISTEN: begin
            end
            K_TALK: begin
                rb[2] = echo;
                if (kbd_hit) begin
                    rb[0] = KBD_FILL;
                    rb[1] = KBD_FILL;
                    rb[3] = KBD_FILL;
                    rb[4] = KBD_FILL;
                    rsp_len = RSP_LEN_W'(5);
                end else begin
                    rsp_len = RSP_LEN_W'(3);
                end
            end
            K_AUTOPOLL: begin
                rb[2]   = echo;
                rsp_len = RSP_LEN_W'(3);
            end
            K_CLOCK: begin
                for (int i = 0; i < SEC_BYTES; i++)
                    rb[i] = secs[SEC_W-1-8*i -: 8];
                rsp_len = RSP_LEN_W'(SEC_BYTES);
            end
            default: rsp_err = 1'b1;
        endcase
    end

    for (genvar g = 0; g < RSP_MAX; g++) begin : g_pack
        assign rsp[g*8 +: 8] = rb[g];
    end

endmodule

// File: rtl/sbr_sec_counter.sv
module sbr_sec_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= preset;
        else if (tick) count <= count + W'(1);
    end
endmodule

// File: rtl/sbr_responder.sv
module sbr_responder
    import sbr_pkg::*;
#(
    parameter int CMD_MAX = 4,
    parameter int LEN_W   = $clog2(CMD_MAX + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [LEN_W-1:0]           cmd_len,
    input  logic [CMD_MAX*8-1:0]       cmd_data,
    input  logic                       sec_tick,
    input  logic                       sec_load,
    input  logic [SEC_W-1:0]           sec_preset,
    output logic                       done,
    output logic                       err,
    output logic [RSP_LEN_W-1:0]       rsp_len,
    output logic [RSP_MAX*8-1:0]       rsp_data
);
    sbr_state_e              state, state_nx;
    logic [CMD_MAX*8-1:0]    cmd_q;
    logic [LEN_W-1:0]        len_q;
    logic [3:0]              kbd_q;
    logic                    err_q;
    logic [SEC_W-1:0]        secs;
    cmd_kind_e               kind;
    logic                    kbd_hit;
    logic [RSP_MAX*8-1:0]    b_rsp;
    logic [RSP_LEN_W-1:0]    b_len;
    logic                    b_err;

    sbr_classifier #(.LEN_W(LEN_W)) u_cls (
        .cmd_bytes (cmd_q[31:0]),
        .cmd_len   (len_q),
        .kbd_addr  (kbd_q),
        .kind      (kind),
        .kbd_hit   (kbd_hit)
    );

    sbr_rsp_builder u_bld (
        .kind    (kind),
        .kbd_hit (kbd_hit),
        .echo    (cmd_q[15:8]),
        .secs    (secs),
        .rsp     (b_rsp),
        .rsp_len (b_len),
        .rsp_err (b_err)
    );

    sbr_sec_counter #(.W(SEC_W)) u_sec (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .load   (sec_load),
        .preset (sec_preset),
        .count  (secs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cmd_valid) state_nx = ST_DECODE;
            ST_DECODE: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            len_q    <= '0;
            kbd_q    <= KBD_RESET_ADDR;
            err_q    <= 1'b0;
            rsp_len  <= '0;
            rsp_data <= '0;
        end else begin
            if (state == ST_IDLE && cmd_valid) begin
                cmd_q <= cmd_data;
                len_q <= cmd_len;
            end
            if (state == ST_DECODE) begin
                rsp_data <= b_rsp;
                rsp_len  <= b_len;
                err_q    <= b_err;
                if (kind == K_LISTEN) kbd_q <= cmd_q[19:16];
            end
        end
    end

    always_comb begin
        done = (state == ST_DONE);
        err  = (state == ST_DONE) && err_q;
    end

endmodule

// File: rtl/sbr_responder_chk.sv
module sbr_responder_chk
    import sbr_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic                  done,
    input logic                  err,
    input logic [RSP_LEN_W-1:0]  rsp_len,
    input logic [RSP_MAX*8-1:0]  rsp_data,
    input logic [3:0]            kbd_q,
    input logic                  sec_load,
    input logic [SEC_W-1:0]      sec_preset,
    input logic [SEC_W-1:0]      secs
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid, 2));

    // R2
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R2
    err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rsp_len == '0 && rsp_data == '0));

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rsp_len) && $stable(rsp_data)));

    // R6
    kbd_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_q != $past(kbd_q)) |-> done);

    // R8
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_load |=> (secs == $past(sec_preset)));

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_len <= RSP_LEN_W'(RSP_MAX));
endmodule

bind sbr_responder sbr_responder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .done       (done),
    .err        (err),
    .rsp_len    (rsp_len),
    .rsp_data   (rsp_data),
    .kbd_q      (kbd_q),
    .sec_load   (sec_load),
    .sec_preset (sec_preset),
    .secs       (secs)
);

// File: tb/test_sbr_responder.sv
module test_sbr_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_len = '0;
    logic [31:0] cmd_data = '0;
    logic        sec_tick = 1'b0;
    logic        sec_load = 1'b0;
    logic [31:0] sec_preset = '0;
    logic        done, err;
    logic [2:0]  rsp_len;
    logic [39:0] rsp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0]  cb [4];
    logic [3:0]  m_kbd = 4'd2;
    logic [31:0] m_secs = '0;
    logic [39:0] e_data;
    int          e_len;
    bit          e_err;
    string       e_tag;

    always #2.5 clk = ~clk;

    sbr_responder i_sbr_responder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
        .cmd_data(cmd_data), .sec_tick(sec_tick), .sec_load(sec_load),
        .sec_preset(sec_preset), .done(done), .err(err),
        .rsp_len(rsp_len), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model(input int len);
        e_data = '0; e_len = 0; e_err = 0; e_tag = "R2";
        if (len < 2) begin
            e_err = 1;
        end else if (cb[0] == 8'd0) begin
            if (cb[1] == 8'd0) begin
                e_tag = "R3";
            end else if (cb[1][3:2] == 2'b11) begin
                if (cb[1][7:4] == m_kbd) begin
                    e_tag = "R5"; e_len = 5;
                    e_data = {8'h01, 8'h01, cb[1], 8'h01, 8'h01};
                end else begin
                    e_tag = "R4"; e_len = 3;
                    e_data = {16'h0, cb[1], 16'h0};
                end
            end else if (cb[1][3:2] == 2'b10) begin
                e_tag = "R6";
                if (len >= 4 && cb[1][7:4] == m_kbd && cb[2][7:4] == 4'h6 &&
                    cb[3] == 8'hFE)
                    m_kbd = cb[2][3:0];
                else
                    e_err = 1;
            end else begin
                e_err = 1;
            end
        end else if (cb[0] == 8'd1) begin
            e_tag = "R9";
            if (len == 3 && cb[1] == 8'h01 && cb[2] == 8'h01) begin
                e_tag = "R7"; e_len = 3; e_data = {16'h0, 8'h01, 16'h0};
            end else if (len == 2 && cb[1] == 8'h03) begin
                e_tag = "R8"; e_len = 4;
                e_data = {8'h0, m_secs[7:0], m_secs[15:8], m_secs[23:16], m_secs[31:24]};
            end else begin
                e_err = 1;
            end
        end else begin
            e_err = 1;
        end
    endfunction

    task automatic run_cmd(input int len, input bit noisy);
        logic [39:0] held;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_len   = 3'(len);
        cmd_data  = {cb[3], cb[2], cb[1], cb[0]};
        model(len);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done early", 40'(done), 40'h0);
        if (noisy) begin
            cmd_data = {8'h00, 8'h00, 8'h2F, 8'h00};
            cmd_len  = 3'd2;
        end else begin
            cmd_valid = 1'b0;
        end
        @(negedge clk);
        chk(done == 1'b1, "R10", "done", 40'(done), 40'h1);
        chk(err == e_err, e_tag, "err", 40'(err), 40'(e_err));
        chk(rsp_len == 3'(e_len), e_tag, "rsp_len", 40'(rsp_len), 40'(e_len));
        chk(rsp_data == e_data, e_tag, "rsp_data", rsp_data, e_data);
        held = rsp_data;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(done == 1'b0 && err == 1'b0, "R10", "done/err after pulse",
            40'({done, err}), 40'h0);
        chk(rsp_data == held && rsp_len == 3'(e_len), "R11", "held reply",
            rsp_data, held);
        if (noisy) begin
            @(negedge clk);
            chk(done == 1'b0, "R10", "busy valid accepted", 40'(done), 40'h0);
            @(negedge clk);
            chk(done == 1'b0, "R10", "busy valid accepted", 40'(done), 40'h0);
        end
    endtask

    task automatic set_cmd(input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input logic [7:0] d);
        cb[0] = a; cb[1] = b; cb[2] = c; cb[3] = d;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
            m_secs = m_secs + 1;
        end
    endtask

    task automatic load(input logic [31:0] v, input bit with_tick);
        @(negedge clk);
        sec_load = 1'b1; sec_preset = v; sec_tick = with_tick;
        @(negedge clk);
        sec_load = 1'b0; sec_tick = 1'b0;
        m_secs = v;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done == 0 && err == 0, "R1", "done/err", 40'({done, err}), 40'h0);
        chk(rsp_len == 0, "R1", "rsp_len", 40'(rsp_len), 40'h0);
        chk(rsp_data == 0, "R1", "rsp_data", rsp_data, 40'h0);
        rst_n = 1'b1;

        // R1/R5: keyboard at address 2 after reset
        set_cmd(8'h00, 8'h2C, 8'h00, 8'h00); run_cmd(2, 0);
        // R4 default talk, R3 bus reset
        set_cmd(8'h00, 8'h3D, 8'h55, 8'h66); run_cmd(4, 0);
        set_cmd(8'h00, 8'h00, 8'h00, 8'h00); run_cmd(2, 0);
        // R2: short command and bad class
        set_cmd(8'h00, 8'h2C, 8'h00, 8'h00); run_cmd(1, 0);
        set_cmd(8'h02, 8'h2C, 8'h00, 8'h00); run_cmd(2, 0);
        // R6: broken listens, each leaves the address
        set_cmd(8'h00, 8'h38, 8'h65, 8'hFE); run_cmd(4, 0);
        set_cmd(8'h00, 8'h28, 8'h75, 8'hFE); run_cmd(4, 0);
        set_cmd(8'h00, 8'h28, 8'h65, 8'hFD); run_cmd(4, 0);
        set_cmd(8'h00, 8'h28, 8'h65, 8'hFE); run_cmd(3, 0);
        set_cmd(8'h00, 8'h2C, 8'h00, 8'h00); run_cmd(2, 0);
        // R6: valid listen moves keyboard to 5
        set_cmd(8'h00, 8'h2A, 8'h65, 8'hFE); run_cmd(4, 0);
        set_cmd(8'h00, 8'h5F, 8'h00, 8'h00); run_cmd(2, 0);
        set_cmd(8'h00, 8'h2F, 8'h00, 8'h00); run_cmd(2, 0);
        // R7 autopoll and R9 wrong-length forms
        set_cmd(8'h01, 8'h01, 8'h01, 8'h00); run_cmd(3, 0);
        set_cmd(8'h01, 8'h01, 8'h01, 8'h00); run_cmd(4, 0);
        set_cmd(8'h01, 8'h11, 8'h00, 8'h00); run_cmd(2, 0);
        set_cmd(8'h01, 8'h03, 8'h00, 8'h00); run_cmd(3, 0);
        // R8: preset, ticks, load beats tick
        load(32'hA1B2_C3D4, 0);
        set_cmd(8'h01, 8'h03, 8'h00, 8'h00); run_cmd(2, 0);
        ticks(3);
        set_cmd(8'h01, 8'h03, 8'h00, 8'h00); run_cmd(2, 0);
        load(32'hFFFF_FFFF, 1);
        ticks(1);
        set_cmd(8'h01, 8'h03, 8'h00, 8'h00); run_cmd(2, 0);
        // R10: valid held while busy
        set_cmd(8'h00, 8'h5C, 8'h00, 8'h00); run_cmd(2, 1);

        for (int n = 0; n < 600; n++) begin
            int t;
            int len;
            t = $urandom % 8;
            set_cmd(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            len = 2 + $urandom % 3;
            case (t)
                0: begin
                    cb[0] = 0; cb[1][3:2] = 2'b11;
                    if ($urandom % 2) cb[1][7:4] = m_kbd;
                end
                1: begin
                    cb[0] = 0; cb[1][3:2] = 2'b10;
                    if ($urandom % 4 != 0) cb[1][7:4] = m_kbd;
                    if ($urandom % 4 != 0) cb[2][7:4] = 4'h6;
                    if ($urandom % 4 != 0) cb[3] = 8'hFE;
                    if ($urandom % 4 != 0) len = 4;
                end
                2: begin cb[0] = 0; cb[1] = 0; end
                3: begin
                    cb[0] = 1;
                    if ($urandom % 2) begin cb[1] = 8'h01; cb[2] = 8'h01; end
                end
                4: begin
                    cb[0] = 1;
                    cb[1] = ($urandom % 4 == 0) ? 8'h11 : 8'h03;
                end
                5: begin
                    cb[0] = 8'($urandom % 4);
                    len = $urandom % 5;
                end
                6: ticks(1 + $urandom % 3);
                default: load($urandom, $urandom % 2);
            endcase
            if (t < 6) run_cmd(len, ($urandom % 8) == 0);
        end
        finish_run();
    end
endmodule